// File: doc/BRIEF.md
# Reciprocal Timestamp Phase-Locked Loop

This block tracks an external reference from edge timestamps captured by a free-running timer. It runs once per processing batch. Each batch update may carry one captured timestamp, or none. The loop keeps a wide frequency accumulator. The accumulator holds the reciprocal of the measured reference period, so it converts timer ticks into phase. Each update produces two words for a downstream numerically controlled oscillator: a 32-bit phase word and a 32-bit phase increment (frequency) word.

All arithmetic uses two's-complement wraparound. The loop gains are powers of two, applied as arithmetic right shifts with round-half-up rounding. The frequency shift and the phase shift are runtime inputs. A larger shift gives a narrower loop bandwidth. `DT2` is the base-2 logarithm of the number of timer ticks that pass between two updates.

The update is spread over three clock cycles. A one-cycle `done_o` pulse marks the point at which both words are final.

Top module: `recip_ts_pll`

## Requirements
- R1: After reset, `phase_o` and `freq_o` read zero and `done_o` is low. The internal tick counter, frequency accumulator and stored previous timestamp are also zero, so that the first update with no timestamp returns phase 0 and frequency 0.
- R2: On each accepted update, the phase word first becomes its old value plus the old frequency word, modulo 2^32. This happens before any timestamp processing.
- R3: The update may carry a valid timestamp `ts`. In that case the 64-bit accumulator `acc` becomes acc + 2^(32+DT2−fs) − ((acc·(ts − prev) + 2^(fs−1)) >>> fs), modulo 2^64. Here `prev` is the previously stored timestamp, `fs` is the frequency shift, the difference wraps at 32 bits and is sign-extended, and the product keeps its low 64 bits.
- R4: After R3, the frequency word becomes low32(acc) + low32((acc·(tick − ts) − (phase << DT2) + 2^(ps−1)) >>> ps). Here `acc` and `phase` are the values just updated, `tick` is the tick counter before this update's advance, `ps` is the phase shift, and the phase is sign-extended to 64 bits.
- R5: The tick counter advances by 2^DT2, modulo 2^32, on every update, whether or not a timestamp is present.
- R6: An update with `ts_vld_i` low leaves the frequency word, the accumulator and the stored previous timestamp unchanged.
- R7: The stored previous timestamp takes the value of each valid timestamp. An update without a timestamp does not change it.
- R8: `upd_i` is sampled at a rising edge while the block is idle. `done_o` then goes high for exactly one cycle, after the second rising edge that follows. While `done_o` is high, both output words are final. A strobe that arrives while an update is in progress is ignored, along with its data.
- R9: While no update is in progress and `upd_i` is low, `phase_o` and `freq_o` hold their values.
- R10: Both shift inputs are captured with the strobe. Each must lie in the range 1 to 32+DT2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe, one per batch |
| ts_vld_i | input | 1 | This update carries a timestamp |
| ts_i | input | 32 | Captured timestamp, signed, in timer ticks |
| fshift_i | input | 6 | Frequency loop shift (1 to 32+DT2) |
| pshift_i | input | 6 | Phase loop shift (1 to 32+DT2) |
| phase_o | output | 32 | Phase word |
| freq_o | output | 32 | Frequency (phase increment) word |
| done_o | output | 1 | One-cycle pulse when the words are final |

## Verification
The sampling edge for a strobe is called edge k. The phase word changes at edge k, the accumulator at edge k+1, and the frequency word and tick counter at edge k+2. `done_o` is high from edge k+2 to edge k+3. The bench drives every input on the falling edge. It checks that `done_o` is low after edges k and k+1, then compares both words and `done_o` after edge k+2. After edge k+3 it checks that `done_o` has fallen and that the words are unchanged. In some runs the bench drives a strobe with different data during the busy cycles, and the next expected values show that this strobe was dropped.

// File: rtl/rtpll_pkg.sv
package rtpll_pkg;

  localparam int unsigned TS_W  = 32;
  localparam int unsigned ACC_W = 2 * TS_W;
  localparam int unsigned SH_W  = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FRQ  = 2'd1,
    ST_PHS  = 2'd2
  } rtpll_state_e;

  // low ACC_W bits of acc * sign-extended b (same for signed and unsigned)
  function automatic logic [ACC_W-1:0] mul_wrap(input logic [ACC_W-1:0] a,
                                                input logic [TS_W-1:0]  b);
    logic [ACC_W-1:0] b_ext;
    b_ext = {{(ACC_W-TS_W){b[TS_W-1]}}, b};
    return a * b_ext;
  endfunction

  // arithmetic right shift with round-half-up, sh >= 1
  function automatic logic [ACC_W-1:0] round_shift(input logic [ACC_W-1:0] x,
                                                   input logic [SH_W-1:0]  sh);
    logic [ACC_W-1:0]        half;
    logic signed [ACC_W-1:0] biased;
    half   = {{(ACC_W-1){1'b0}}, 1'b1} << (sh - 1'b1);
    biased = $signed(x + half);
    return $unsigned(biased >>> sh);
  endfunction

endpackage

// File: rtl/rtpll_ctrl.sv
module rtpll_ctrl
  import rtpll_pkg::*;
#(
  parameter int unsigned DT2 = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_i,
  input  logic            ts_vld_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic [SH_W-1:0] fshift_i,
  input  logic [SH_W-1:0] pshift_i,
  output logic            accept_o,
  output logic            frq_en_o,
  output logic            phs_en_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            vld_o,
  output logic [TS_W-1:0] ts_o,
  output logic [SH_W-1:0] fshift_o,
  output logic [SH_W-1:0] pshift_o
);

  localparam int unsigned SH_MAX = TS_W + DT2;

  rtpll_state_e    state_q, state_d;
  logic            done_q, done_d;
  logic            vld_q;
  logic [TS_W-1:0] ts_q;
  logic [SH_W-1:0] fs_q, ps_q;

  assign accept_o = upd_i && (state_q == ST_IDLE);
  assign frq_en_o = (state_q == ST_FRQ);
  assign phs_en_o = (state_q == ST_PHS);
  assign busy_o   = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (upd_i) state_d = ST_FRQ;
      ST_FRQ:  state_d = ST_PHS;
      ST_PHS:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_PHS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // operand capture, enabled only on an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ts_q  <= '0;
      fs_q  <= SH_W'(1);
      ps_q  <= SH_W'(1);
    end else if (accept_o) begin
      vld_q <= ts_vld_i;
      ts_q  <= ts_i;
      fs_q  <= fshift_i;
      ps_q  <= pshift_i;
    end
  end

  assign done_o   = done_q;
  assign vld_o    = vld_q;
  assign ts_o     = ts_q;
  assign fshift_o = fs_q;
  assign pshift_o = ps_q;

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: done follows the accepting edge by a fixed latency
  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> ##1 ##1 done_o);

  // R10: shift settings in range when captured
  assert_shift_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (fshift_i >= 1 && 32'(fshift_i) <= SH_MAX &&
                  pshift_i >= 1 && 32'(pshift_i) <= SH_MAX));

endmodule

// File: rtl/rtpll_freq_est.sv
module rtpll_freq_est
  import rtpll_pkg::*;
#(
  parameter int unsigned DT2 = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [SH_W-1:0]  fshift_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam logic [SH_W:0] GAIN_BASE = (SH_W+1)'(TS_W + DT2);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [TS_W-1:0]  prev_q, prev_d;
  logic             load;

  logic [SH_W:0]    inc_sh;
  logic [ACC_W-1:0] inc;
  logic [TS_W-1:0]  period;
  logic [ACC_W-1:0] corr;

  assign load = en_i && vld_i;

  always_comb begin
    inc_sh = GAIN_BASE - {1'b0, fshift_i};
    inc    = {{(ACC_W-1){1'b0}}, 1'b1} << inc_sh;
    period = ts_i - prev_q;
    corr   = round_shift(mul_wrap(acc_q, period), fshift_i);
    acc_d  = acc_q;
    prev_d = prev_q;
    if (load) begin
      acc_d  = acc_q + inc - corr;
      prev_d = ts_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      prev_q <= '0;
    end else if (load) begin
      acc_q  <= acc_d;
      prev_q <= prev_d;
    end
  end

  assign acc_o = acc_q;

  // R6/R7: an update without a timestamp touches neither accumulator nor previous stamp
  assert_no_ts_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !vld_i) |=> ($stable(acc_q) && $stable(prev_q)));

  // R7: previous stamp only moves in a timestamp update
  assert_prev_only_on_ts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(prev_q));

endmodule

// File: rtl/rtpll_phase_acc.sv
module rtpll_phase_acc
  import rtpll_pkg::*;
#(
  parameter int unsigned DT2 = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             fin_i,
  input  logic             vld_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [SH_W-1:0]  pshift_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [TS_W-1:0]  phase_o,
  output logic [TS_W-1:0]  freq_o
);

  localparam logic [TS_W-1:0] TICK_STEP = TS_W'(1) << DT2;

  logic [TS_W-1:0]  phase_q, phase_d;
  logic [TS_W-1:0]  freq_q,  freq_d;
  logic [TS_W-1:0]  tick_q,  tick_d;
  logic             freq_load;

  logic [TS_W-1:0]  lag;
  logic [ACC_W-1:0] phase_ext;
  logic [ACC_W-1:0] err;
  logic [ACC_W-1:0] trim;

  assign freq_load = fin_i && vld_i;

  always_comb begin
    phase_d   = phase_q + freq_q;
    tick_d    = tick_q + TICK_STEP;
    lag       = tick_q - ts_i;
    phase_ext = {{(ACC_W-TS_W){phase_q[TS_W-1]}}, phase_q} << DT2;
    err       = mul_wrap(acc_i, lag) - phase_ext;
    trim      = round_shift(err, pshift_i);
    freq_d    = acc_i[TS_W-1:0] + trim[TS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (adv_i) begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (fin_i) begin
      tick_q <= tick_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
    end else if (freq_load) begin
      freq_q <= freq_d;
    end
  end

  assign phase_o = phase_q;
  assign freq_o  = freq_q;

  // R6: frequency word holds through an update without a timestamp
  assert_freq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && !vld_i) |=> $stable(freq_q));

  // R2: phase moves only on the accepting edge
  assert_phase_only_on_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(phase_q));

  // R5: tick counter moves only at the end of an update
  assert_tick_only_on_fin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(tick_q));

endmodule

// File: rtl/recip_ts_pll.sv
module recip_ts_pll
  import rtpll_pkg::*;
#(
  parameter int unsigned DT2 = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_i,
  input  logic        ts_vld_i,
  input  logic [31:0] ts_i,
  input  logic [5:0]  fshift_i,
  input  logic [5:0]  pshift_i,
  output logic [31:0] phase_o,
  output logic [31:0] freq_o,
  output logic        done_o
);

  logic             accept, frq_en, phs_en, busy;
  logic             vld_q;
  logic [TS_W-1:0]  ts_q;
  logic [SH_W-1:0]  fs_q, ps_q;
  logic [ACC_W-1:0] acc;

  rtpll_ctrl #(.DT2(DT2)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (upd_i),
    .ts_vld_i (ts_vld_i),
    .ts_i     (ts_i),
    .fshift_i (fshift_i),
    .pshift_i (pshift_i),
    .accept_o (accept),
    .frq_en_o (frq_en),
    .phs_en_o (phs_en),
    .busy_o   (busy),
    .done_o   (done_o),
    .vld_o    (vld_q),
    .ts_o     (ts_q),
    .fshift_o (fs_q),
    .pshift_o (ps_q)
  );

  rtpll_freq_est #(.DT2(DT2)) u_freq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (frq_en),
    .vld_i    (vld_q),
    .ts_i     (ts_q),
    .fshift_i (fs_q),
    .acc_o    (acc)
  );

  rtpll_phase_acc #(.DT2(DT2)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (accept),
    .fin_i    (phs_en),
    .vld_i    (vld_q),
    .ts_i     (ts_q),
    .pshift_i (ps_q),
    .acc_i    (acc),
    .phase_o  (phase_o),
    .freq_o   (freq_o)
  );

  // R9: outputs hold while idle with no strobe
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !upd_i) |=> ($stable(phase_o) && $stable(freq_o)));

endmodule

// File: tb/recip_ts_pll_tb.sv
module recip_ts_pll_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DT2        = 11;
  localparam int SH_MAX     = 32 + DT2;

  logic        clk;
  logic        rst_n;
  logic        upd_i;
  logic        ts_vld_i;
  logic [31:0] ts_i;
  logic [5:0]  fshift_i;
  logic [5:0]  pshift_i;
  logic [31:0] phase_o;
  logic [31:0] freq_o;
  logic        done_o;

  int n_checks;
  int n_errors;
  bit finished;

  // reference model state
  longint m_acc;
  int     m_tick;
  int     m_phase;
  int     m_prev;
  int     m_freq;

  recip_ts_pll #(.DT2(DT2)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (upd_i),
    .ts_vld_i (ts_vld_i),
    .ts_i     (ts_i),
    .fshift_i (fshift_i),
    .pshift_i (pshift_i),
    .phase_o  (phase_o),
    .freq_o   (freq_o),
    .done_o   (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint rshift(input longint x, input int sh);
    return (x + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  // model of one update per R2..R7
  task automatic model_update(input bit v, input int ts, input int fs, input int ps);
    int     d;
    int     lag;
    longint q;
    m_phase = m_phase + m_freq;
    if (v) begin
      d     = ts - m_prev;
      m_acc = m_acc + (longint'(1) <<< (32 + DT2 - fs)) - rshift(m_acc * longint'(d), fs);
      lag   = m_tick - ts;
      q     = rshift(m_acc * longint'(lag) - (longint'(m_phase) <<< DT2), ps);
      m_freq = int'(m_acc) + int'(q);
      m_prev = ts;
    end
    m_tick = m_tick + (1 << DT2);
  endtask

  task automatic run_update(input bit v, input int ts, input int fs, input int ps,
                            input bit poke_busy, input string tag);
    @(negedge clk);
    upd_i = 1'b1; ts_vld_i = v; ts_i = ts; fshift_i = 6'(fs); pshift_i = 6'(ps);
    model_update(v, ts, fs, ps);
    @(negedge clk);                          // after edge k
    if (poke_busy) begin
      upd_i = 1'b1; ts_vld_i = 1'b1; ts_i = $urandom; fshift_i = 6'd1; pshift_i = 6'd1;
    end else upd_i = 1'b0;
    check(done_o == 1'b0, {"R8 early done ", tag}, done_o, 0);
    @(negedge clk);                          // after edge k+1
    upd_i = 1'b0; ts_vld_i = 1'b0;
    check(done_o == 1'b0, {"R8 early done ", tag}, done_o, 0);
    @(negedge clk);                          // after edge k+2
    check(done_o == 1'b1, {"R8 done ", tag}, done_o, 1);
    check(phase_o == 32'(m_phase), {"R2 phase ", tag}, phase_o, 32'(m_phase));
    check(freq_o == 32'(m_freq), {v ? "R4 freq " : "R6 freq ", tag}, freq_o, 32'(m_freq));
    @(negedge clk);                          // after edge k+3
    check(done_o == 1'b0, {"R8 pulse ", tag}, done_o, 0);
    check(phase_o == 32'(m_phase) && freq_o == 32'(m_freq), {"R9 hold ", tag},
          {phase_o, freq_o}, {32'(m_phase), 32'(m_freq)});
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    n_checks = 0; n_errors = 0; finished = 0;
    m_acc = 0; m_tick = 0; m_phase = 0; m_prev = 0; m_freq = 0;
    rst_n = 1'b0; upd_i = 1'b0; ts_vld_i = 1'b0; ts_i = '0;
    fshift_i = 6'd4; pshift_i = 6'd3;
    repeat (3) @(negedge clk);
    check(phase_o == 0 && freq_o == 0 && done_o == 0, "R1 reset outputs",
          {phase_o, freq_o}, 0);
    rst_n = 1'b1;

    // R1: first update with no stamp gives zero words
    run_update(1'b0, 0, 4, 3, 1'b0, "R1 first");

    // R3/R4/R5/R7: periodic stamps, moderate gains
    for (int i = 0; i < 8; i++)
      run_update(1'b1, i * 2000 + 77, 4, 3, 1'b0, "R3 periodic");

    // R6/R7: gaps without stamps, then stamps resume
    run_update(1'b0, 32'h1234_5678, 4, 3, 1'b0, "R6 gap");
    run_update(1'b0, 32'h0BAD_F00D, 4, 3, 1'b0, "R6 gap");
    run_update(1'b1, 20077, 4, 3, 1'b0, "R7 resume");

    // R10: extreme shift settings
    run_update(1'b1, 22100, 1, SH_MAX, 1'b0, "R10 edges");
    run_update(1'b1, 24100, SH_MAX, 1, 1'b0, "R10 edges");
    run_update(1'b1, 26100, 21, 21, 1'b0, "R10 nominal");

    // R8: strobe during busy cycles is dropped
    run_update(1'b1, 28100, 21, 21, 1'b1, "R8 busy strobe");
    run_update(1'b0, 0, 21, 21, 1'b1, "R8 busy strobe");

    // R5 wrap and random mix
    for (int i = 0; i < 150; i++) begin
      bit v;
      int fs, ps;
      v  = ($urandom % 4) != 0;
      fs = 1 + int'($urandom % SH_MAX);
      ps = 1 + int'($urandom % SH_MAX);
      run_update(v, int'($urandom), fs, ps, ($urandom % 5) == 0, "R3 random");
    end

    // R9: idle hold over several cycles
    repeat (5) begin
      @(negedge clk);
      check(phase_o == 32'(m_phase) && freq_o == 32'(m_freq) && !done_o, "R9 idle",
            {phase_o, freq_o}, {32'(m_phase), 32'(m_freq)});
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule